// File: doc/BRIEF.md
# Debug Memory Access Port

This block sits behind a debug port and gives it word-wide access to a system memory bus. The debug port presents a register access (read or write, a 2-bit register index, and write data) under a request/acknowledge handshake, together with a 4-bit bank number it keeps in its own select register. The block joins bank number and index into an 8-bit register offset and either serves a local register or launches one 32-bit transaction on a valid/ready memory bus.

Locally it holds a control/status word and a transfer address. It also offers two constant read-only words: the location of the ROM table and an identification value. A direct data register reaches the full transfer address. Four banked data registers reach the four words of the 16-byte aligned window around that address without rewriting it. Any access to a data register runs a bus transaction, and the acknowledge is withheld until the bus completes.

Top module: `dmap_port`

## Requirements
- R1: After synchronous reset `dbg_ack` and `mem_valid` are low, and the transfer address and control/status words read back as zero.
- R2: The register offset is {`dbg_bank`, `dbg_idx`, 2'b00}. Offset 0x04 is the transfer address: a write stores `dbg_wdata`, and a read returns the stored value.
- R3: Offset 0x00 is the control/status word. Bit 7 is the transaction-in-progress flag. It is read-only and reads 0 whenever the debug port can observe it. The other 31 bits store what is written.
- R4: Offset 0xF8 returns parameter `BASE_VAL` and offset 0xFC returns parameter `ID_VAL`. Writes to either are ignored.
- R5: Every other offset that is not a data register (for example 0x08, 0x20, 0x84, 0xF0, 0xF4) reads as zero and ignores writes. None of these starts a bus transaction.
- R6: An access to offset 0x0C starts exactly one bus transaction at the full transfer address.
- R7: An access to offset 0x10+4n (n = 0..3) starts exactly one bus transaction at {TAR[31:4], n, 2'b00}.
- R8: A data-register write drives `dbg_wdata` on `mem_wdata` with `mem_we`=1. A data-register read has `mem_we`=0 and returns `mem_rdata` on `dbg_rdata`.
- R9: While `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_addr`, `mem_wdata` and `mem_we` hold steady.
- R10: `dbg_ack` is a one-cycle pulse. The debug port keeps its request fields stable until the pulse and drops `dbg_req` in the cycle after it.
- R11: While a bus transaction is outstanding, `dbg_ack` stays low and no new request is taken. The acknowledge follows in the cycle after the `mem_valid`/`mem_ready` handshake edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dbg_req | input | 1 | Access request, held until acknowledged |
| dbg_wr | input | 1 | 1 = write, 0 = read |
| dbg_bank | input | 4 | Bank number, offset bits [7:4] |
| dbg_idx | input | 2 | Register index, offset bits [3:2] |
| dbg_wdata | input | 32 | Write data |
| dbg_ack | output | 1 | One-cycle completion pulse |
| dbg_rdata | output | 32 | Read data, valid with `dbg_ack` |
| mem_valid | output | 1 | Bus request valid |
| mem_ready | input | 1 | Bus request accepted and completed |
| mem_addr | output | 32 | Bus byte address |
| mem_wdata | output | 32 | Bus write data |
| mem_we | output | 1 | Bus write enable |
| mem_rdata | input | 32 | Bus read data, valid with `mem_ready` |

## Verification
A local register access is taken at the first clock edge that sees the request, so the acknowledge is due one cycle after the request is presented. A data-register access raises `mem_valid` at that first edge. The bench memory raises `mem_ready` a programmable number of stall cycles later, and the acknowledge follows one edge after the handshake: a total of 3 + stall cycles. Each access task counts falling edges from request to acknowledge and compares the count with these figures. It samples every output on the falling edge, and also checks that the acknowledge stays low for as long as `mem_valid` is pending. The bench memory records the address, the direction and the number of bus transactions, so the target address of each access and the absence of traffic for reserved offsets are checked at the ports.

// File: rtl/dmap_pkg.sv
package dmap_pkg;
  typedef enum logic [2:0] {
    K_CTRL,
    K_ADDR,
    K_DIRECT,
    K_BANKED,
    K_BASE,
    K_IDENT,
    K_NONE
  } reg_kind_e;

  typedef enum logic [1:0] {
    S_IDLE,
    S_BUS,
    S_DONE
  } port_state_e;
endpackage

// File: rtl/dmap_decode.sv
module dmap_decode
  import dmap_pkg::*;
#(
  parameter int BANK_W = 4,
  parameter int IDX_W  = 2
) (
  input  logic [BANK_W-1:0] bank,
  input  logic [IDX_W-1:0]  idx,
  output reg_kind_e         kind
);
  localparam int OFS_W = BANK_W + IDX_W + 2;

  logic [OFS_W-1:0] ofs;
  assign ofs = {bank, idx, 2'b00};

  always_comb begin
    unique case (ofs)
      8'h00:                      kind = K_CTRL;
      8'h04:                      kind = K_ADDR;
      8'h0C:                      kind = K_DIRECT;
      8'h10, 8'h14, 8'h18, 8'h1C: kind = K_BANKED;
      8'hF8:                      kind = K_BASE;
      8'hFC:                      kind = K_IDENT;
      default:                    kind = K_NONE;
    endcase
  end
endmodule

// File: rtl/dmap_regs.sv
module dmap_regs
  import dmap_pkg::*;
#(
  parameter int          DATA_W   = 32,
  parameter int          BUSY_BIT = 7,
  parameter logic [31:0] BASE_VAL = 32'hE00F_F003,
  parameter logic [31:0] ID_VAL   = 32'h2477_0011
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  reg_kind_e         kind,
  input  logic [DATA_W-1:0] wdata,
  input  logic              busy,
  output logic [DATA_W-1:0] tar,
  output logic [DATA_W-1:0] rd_val
);
  localparam logic [DATA_W-1:0] BUSY_MASK = DATA_W'(1) << BUSY_BIT;

  logic [DATA_W-1:0] ctrl_q;
  logic [DATA_W-1:0] tar_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      tar_q  <= '0;
    end else if (wr_en) begin
      if (kind == K_CTRL) ctrl_q <= wdata & ~BUSY_MASK;
      if (kind == K_ADDR) tar_q  <= wdata;
    end
  end

  always_comb begin
    case (kind)
      K_CTRL:  rd_val = ctrl_q | (busy ? BUSY_MASK : '0);
      K_ADDR:  rd_val = tar_q;
      K_BASE:  rd_val = BASE_VAL;
      K_IDENT: rd_val = ID_VAL;
      default: rd_val = '0;
    endcase
  end

  assign tar = tar_q;

  // R3: the in-progress flag is never stored in the control word
  a_r3_busy_not_stored: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (ctrl_q[BUSY_BIT] == 1'b0));
endmodule

// File: rtl/dmap_busctl.sv
module dmap_busctl
  import dmap_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              wr,
  input  reg_kind_e         kind,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] tar,
  input  logic [DATA_W-1:0] reg_rdata,
  output logic              reg_we,
  output logic              busy,
  output logic              ack,
  output logic [DATA_W-1:0] rdata,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  input  logic [DATA_W-1:0] mem_rdata
);
  localparam int LOW_W = IDX_W + 2;

  port_state_e st;
  logic        take;
  logic        is_data;

  assign take    = (st == S_IDLE) && req && !ack;
  assign is_data = (kind == K_DIRECT) || (kind == K_BANKED);
  assign reg_we  = take && wr && !is_data;
  assign busy    = (st == S_BUS);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      ack       <= 1'b0;
      rdata     <= '0;
      mem_valid <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      mem_we    <= 1'b0;
    end else begin
      unique case (st)
        S_IDLE: begin
          if (take) begin
            if (is_data) begin
              mem_valid <= 1'b1;
              mem_we    <= wr;
              mem_wdata <= wdata;
              mem_addr  <= (kind == K_DIRECT) ? tar
                         : {tar[ADDR_W-1:LOW_W], idx, 2'b00};
              st        <= S_BUS;
            end else begin
              rdata <= wr ? '0 : reg_rdata;
              ack   <= 1'b1;
              st    <= S_DONE;
            end
          end
        end
        S_BUS: begin
          if (mem_ready) begin
            mem_valid <= 1'b0;
            rdata     <= mem_we ? '0 : mem_rdata;
            ack       <= 1'b1;
            st        <= S_DONE;
          end
        end
        S_DONE: begin
          ack <= 1'b0;
          st  <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R9: request fields hold until accepted
  a_r9_hold_req: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr)
                                   && $stable(mem_wdata) && $stable(mem_we)));

  // R10: acknowledge lasts one cycle
  a_r10_ack_pulse: assert property (@(posedge clk) disable iff (rst)
    ack |=> !ack);

  // R11: no acknowledge while the bus access is pending
  a_r11_no_ack_busy: assert property (@(posedge clk) disable iff (rst)
    mem_valid |-> !ack);

  // R5: a non-data access never raises a bus request
  a_r5_no_bus_for_regs: assert property (@(posedge clk) disable iff (rst)
    (take && !is_data) |=> !mem_valid);

  // R6: bus requests start only from an idle port
  a_r6_start_from_idle: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_valid) |-> ($past(st) == S_IDLE));
endmodule

// File: rtl/dmap_port.sv
module dmap_port
  import dmap_pkg::*;
#(
  parameter int          ADDR_W   = 32,
  parameter int          DATA_W   = 32,
  parameter int          BANK_W   = 4,
  parameter int          IDX_W    = 2,
  parameter int          BUSY_BIT = 7,
  parameter logic [31:0] BASE_VAL = 32'hE00F_F003,
  parameter logic [31:0] ID_VAL   = 32'h2477_0011
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dbg_req,
  input  logic              dbg_wr,
  input  logic [BANK_W-1:0] dbg_bank,
  input  logic [IDX_W-1:0]  dbg_idx,
  input  logic [DATA_W-1:0] dbg_wdata,
  output logic              dbg_ack,
  output logic [DATA_W-1:0] dbg_rdata,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  input  logic [DATA_W-1:0] mem_rdata
);
  reg_kind_e         kind;
  logic [DATA_W-1:0] tar;
  logic [DATA_W-1:0] reg_rdata;
  logic              reg_we;
  logic              busy;

  dmap_decode #(.BANK_W(BANK_W), .IDX_W(IDX_W)) u_decode (
    .bank (dbg_bank),
    .idx  (dbg_idx),
    .kind (kind)
  );

  dmap_regs #(
    .DATA_W(DATA_W), .BUSY_BIT(BUSY_BIT),
    .BASE_VAL(BASE_VAL), .ID_VAL(ID_VAL)
  ) u_regs (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (reg_we),
    .kind   (kind),
    .wdata  (dbg_wdata),
    .busy   (busy),
    .tar    (tar),
    .rd_val (reg_rdata)
  );

  dmap_busctl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_busctl (
    .clk       (clk),
    .rst       (rst),
    .req       (dbg_req),
    .wr        (dbg_wr),
    .kind      (kind),
    .idx       (dbg_idx),
    .wdata     (dbg_wdata),
    .tar       (tar),
    .reg_rdata (reg_rdata),
    .reg_we    (reg_we),
    .busy      (busy),
    .ack       (dbg_ack),
    .rdata     (dbg_rdata),
    .mem_valid (mem_valid),
    .mem_ready (mem_ready),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_we    (mem_we),
    .mem_rdata (mem_rdata)
  );
endmodule

// File: tb/dmap_port_bench.sv
module dmap_port_bench;
  localparam logic [31:0] BASE = 32'hE00F_F003;
  localparam logic [31:0] IDV  = 32'h2477_0011;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        dbg_req = 1'b0, dbg_wr = 1'b0;
  logic [3:0]  dbg_bank = '0;
  logic [1:0]  dbg_idx = '0;
  logic [31:0] dbg_wdata = '0;
  logic        dbg_ack;
  logic [31:0] dbg_rdata;
  logic        mem_valid, mem_we;
  logic        mem_ready;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;

  int n_chk = 0, n_bad = 0;
  int stall = 0;
  int wait_cnt;
  int n_tx;
  logic [31:0] last_addr;
  logic        last_we;
  logic [31:0] mem [16];

  always #5 clk = ~clk;

  dmap_port #(.BASE_VAL(BASE), .ID_VAL(IDV)) u_dmap_port (
    .clk(clk), .rst(rst), .dbg_req(dbg_req), .dbg_wr(dbg_wr),
    .dbg_bank(dbg_bank), .dbg_idx(dbg_idx), .dbg_wdata(dbg_wdata),
    .dbg_ack(dbg_ack), .dbg_rdata(dbg_rdata), .mem_valid(mem_valid),
    .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_rdata(mem_rdata)
  );

  // memory model with programmable stall
  always @(posedge clk) begin
    if (rst) begin
      mem_ready <= 1'b0; mem_rdata <= '0; wait_cnt <= 0;
      n_tx <= 0; last_addr <= '0; last_we <= 1'b0;
      for (int i = 0; i < 16; i++) mem[i] <= 32'hA000_0000 + 32'(i);
    end else if (mem_ready) begin
      mem_ready <= 1'b0; wait_cnt <= 0;
    end else if (mem_valid) begin
      if (wait_cnt == stall) begin
        mem_ready <= 1'b1;
        n_tx      <= n_tx + 1;
        last_addr <= mem_addr;
        last_we   <= mem_we;
        if (mem_we) mem[mem_addr[5:2]] <= mem_wdata;
        else mem_rdata <= mem[mem_addr[5:2]];
      end else wait_cnt <= wait_cnt + 1;
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [3:0] bank,
                        input logic [1:0] idx, input logic [31:0] wd,
                        output logic [31:0] rd, output int cyc,
                        output logic ack_in_busy);
    @(negedge clk);
    dbg_req = 1'b1; dbg_wr = wr; dbg_bank = bank; dbg_idx = idx; dbg_wdata = wd;
    cyc = 0; ack_in_busy = 1'b0;
    do begin
      @(negedge clk);
      cyc++;
      if (mem_valid && dbg_ack) ack_in_busy = 1'b1;
    end while (!dbg_ack && cyc < 50);
    rd = dbg_rdata;
    dbg_req = 1'b0;
    @(negedge clk);
    check("R10 ack one cycle", {31'b0, dbg_ack}, 32'd0);
  endtask

  task automatic reg_rd(input logic [3:0] b, input logic [1:0] i, output logic [31:0] rd);
    int c; logic x;
    access(1'b0, b, i, '0, rd, c, x);
    check("R10 register ack latency", c, 1);
  endtask

  task automatic reg_wr(input logic [3:0] b, input logic [1:0] i, input logic [31:0] wd);
    int c; logic x; logic [31:0] rd;
    access(1'b1, b, i, wd, rd, c, x);
    check("R10 register ack latency", c, 1);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R1 ack low", {31'b0, dbg_ack}, 0);
    check("R1 mem_valid low", {31'b0, mem_valid}, 0);
    reg_rd(4'h0, 2'd1, v); check("R1 transfer address zero", v, 0);
    reg_rd(4'h0, 2'd0, v); check("R1 control word zero", v, 0);
  endtask

  task automatic t_local_regs();
    logic [31:0] v;
    reg_wr(4'h0, 2'd1, 32'hCAFE_0124);
    reg_rd(4'h0, 2'd1, v); check("R2 transfer address readback", v, 32'hCAFE_0124);
    reg_wr(4'h0, 2'd0, 32'hFFFF_FFFF);
    reg_rd(4'h0, 2'd0, v); check("R3 control word busy bit read-only", v, 32'hFFFF_FF7F);
    reg_wr(4'h0, 2'd0, 32'h0000_0012);
    reg_rd(4'h0, 2'd0, v); check("R3 control word readback", v, 32'h0000_0012);
  endtask

  task automatic t_ro_regs();
    logic [31:0] v;
    reg_wr(4'hF, 2'd2, 32'h1111_1111);
    reg_wr(4'hF, 2'd3, 32'h2222_2222);
    reg_rd(4'hF, 2'd2, v); check("R4 base address value", v, BASE);
    reg_rd(4'hF, 2'd3, v); check("R4 identification value", v, IDV);
  endtask

  task automatic t_reserved();
    logic [31:0] v; int tx0;
    logic [3:0] bl [5] = '{4'h0, 4'h2, 4'h8, 4'hF, 4'hF};
    logic [1:0] il [5] = '{2'd2, 2'd0, 2'd1, 2'd0, 2'd1};
    tx0 = n_tx;
    for (int k = 0; k < 5; k++) begin
      reg_wr(bl[k], il[k], 32'h5A5A_5A5A);
      reg_rd(bl[k], il[k], v);
      check("R5 reserved reads zero", v, 0);
    end
    reg_rd(4'h0, 2'd1, v); check("R5 reserved write left address intact", v, 32'hCAFE_0124);
    reg_rd(4'h0, 2'd0, v); check("R5 reserved write left control intact", v, 32'h0000_0012);
    check("R5 no bus traffic", n_tx - tx0, 0);
  endtask

  task automatic t_direct(int s);
    logic [31:0] v; int c, tx0; logic bad;
    stall = s;
    reg_wr(4'h0, 2'd1, 32'h1234_5678);
    tx0 = n_tx;
    access(1'b1, 4'h0, 2'd3, 32'hDEAD_0001 + 32'(s), v, c, bad);
    check("R6 direct write address", last_addr, 32'h1234_5678);
    check("R8 direct write enable", {31'b0, last_we}, 1);
    check("R8 written word in memory", mem[14], 32'hDEAD_0001 + 32'(s));
    check("R11 bus ack latency", c, 3 + s);
    check("R11 no ack while pending", {31'b0, bad}, 0);
    access(1'b0, 4'h0, 2'd3, '0, v, c, bad);
    check("R8 direct read data", v, 32'hDEAD_0001 + 32'(s));
    check("R8 direct read enable low", {31'b0, last_we}, 0);
    check("R6 one transaction each", n_tx - tx0, 2);
    check("R11 bus ack latency read", c, 3 + s);
    stall = 0;
  endtask

  task automatic t_banked();
    logic [31:0] v; int c, tx0; logic bad;
    stall = 1;
    for (int n = 0; n < 4; n++) begin
      tx0 = n_tx;
      access(1'b1, 4'h1, 2'(n), 32'hB000_0000 + 32'(n), v, c, bad);
      check("R7 banked write address", last_addr, 32'h1234_5670 + 32'(4 * n));
      check("R7 one transaction", n_tx - tx0, 1);
    end
    for (int n = 3; n >= 0; n--) begin
      access(1'b0, 4'h1, 2'(n), '0, v, c, bad);
      check("R7 banked read address", last_addr, 32'h1234_5670 + 32'(4 * n));
      check("R8 banked read data", v, 32'hB000_0000 + 32'(n));
      check("R11 no ack while pending", {31'b0, bad}, 0);
    end
    reg_rd(4'h0, 2'd1, v); check("R7 address register unchanged", v, 32'h1234_5678);
    reg_rd(4'h0, 2'd0, v); check("R3 busy reads zero after access", v, 32'h0000_0012);
    stall = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_local_regs();
    t_ro_regs();
    t_reserved();
    t_direct(0);
    t_direct(3);
    t_banked();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule